// File: doc/BRIEF.md
# I2C Slave Receiver with General Call Recognition

This block is the receive front end of an I2C slave. It brings SCL and SDA into the core clock domain, finds Start and Stop conditions, and shifts in bytes on SCL rising edges. The first byte after a Start is checked against a programmable own address and against the fixed general call address (all zeros, write). A byte that matches is acknowledged by pulling SDA low during the ninth clock. It is then copied into a receive buffer, and the buffer-full and interrupt flags are raised. Software can tell a general call from an own-address hit by reading the buffered address byte.

Both 7-bit and 10-bit addressing are supported. In 10-bit mode the first byte carries a fixed prefix and the two upper address bits. Accepting it raises an update-address flag. Software clears that flag once the low address byte is in place, and only then can the second address byte match. A general call received in 10-bit mode skips the second address byte entirely: no update-address request is raised, and data bytes follow the ACK directly. A byte that completes while the buffer is still full is refused and flagged as an overflow. Read direction, clock stretching and arbitration are not handled; an own-address byte with the read bit set is treated as a non-match.

Top module: `i2c_gc_slave`

## Requirements
- R1: SCL and SDA pass through two synchronizer flops. A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. Outside a Start..Stop frame, bus activity causes no ACK and no flag change.
- R2: Bits enter MSB first on SCL rising edges. In 7-bit mode (ten_bit_i=0), the first byte is acknowledged only when bits [7:1] equal own_addr_i[6:0] and bit 0 (read/write) is 0.
- R3: The first byte 8'h00 is acknowledged as a general call only when gc_en_i=1, in either addressing mode. With gc_en_i=0 it is refused.
- R4: For an accepted byte, sda_oe_o is asserted after the eighth SCL falling edge and released after the ninth. A refused byte gets no ACK, and the block then ignores the bus until the next Start.
- R5: An accepted byte is copied to rx_data_o and bf_o is set at the eighth SCL rising edge. buf_rd_i clears bf_o. A general call leaves 8'h00 in rx_data_o.
- R6: irq_o is set at the ninth SCL falling edge of every acknowledged byte and is cleared by irq_clr_i. Setting wins over clearing.
- R7: In 10-bit mode, the first byte is accepted only if it equals {5'b11110, own_addr_i[9:8], 1'b0}. Acceptance sets ua_o, which is cleared by ua_clr_i.
- R8: In 10-bit mode, the second byte is acknowledged only if it equals own_addr_i[7:0] and ua_o has already been cleared. Otherwise it is refused.
- R9: A general call in 10-bit mode does not set ua_o, and the very next byte is handled as data.
- R10: After the address phase succeeds, every following byte is a data byte. Each is acknowledged and buffered until a Stop or Start.
- R11: A byte that would be accepted while bf_o is set raises ov_o (cleared by ov_clr_i). It is not acknowledged, leaves rx_data_o unchanged, and returns the block to idle.
- R12: A buf_rd_i pulse in the same cycle as the eighth rising edge frees the buffer. The new byte is then accepted without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK) |
| own_addr_i | input | 10 | Own slave address; [6:0] used in 7-bit mode |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gc_en_i | input | 1 | Enables general call recognition |
| buf_rd_i | input | 1 | Buffer read strobe, clears bf_o |
| irq_clr_i | input | 1 | Clears irq_o |
| ua_clr_i | input | 1 | Clears ua_o after the address update |
| ov_clr_i | input | 1 | Clears ov_o |
| rx_data_o | output | 8 | Receive buffer |
| bf_o | output | 1 | Buffer full |
| irq_o | output | 1 | Interrupt flag |
| ua_o | output | 1 | Update-address request |
| ov_o | output | 1 | Receive overflow |

## Verification
The contested cycle is the one where a byte completes while software reads the buffer: the same edge can both set and clear bf_o. The bench holds the buffer full and then places a one-cycle buf_rd_i pulse one cycle early, exactly on, and one cycle late relative to the synchronized eighth SCL rise. The early and coincident reads must give an ACK with the new byte in rx_data_o and no overflow. The late read must give a refused byte, a raised ov_o and an unchanged buffer.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_DATA
  } st_e;
endpackage

// File: rtl/i2c_gc_line_sync.sv
module i2c_gc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  logic scl_s;
  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_gc_shifter.sv
module i2c_gc_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] next_byte_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= next_byte_o;
  end

  assign next_byte_o = {sr_q[W-2:0], bit_i};
endmodule

// File: rtl/i2c_gc_addr_match.sv
module i2c_gc_addr_match
  import i2c_gc_pkg::*;
(
  input  st_e               st_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              ten_bit_i,
  input  logic              ua_pend_i,
  output logic              hit_o,
  output logic              hi10_o
);
  logic gc, own7, hi10;

  assign gc   = gc_en_i && (byte_i == '0);
  assign own7 = !ten_bit_i && (byte_i[7:1] == own_addr_i[6:0]) && !byte_i[0];
  assign hi10 = ten_bit_i && (byte_i == {TEN_PREFIX, own_addr_i[9:8], 1'b0});

  always_comb begin
    unique case (st_i)
      ST_ADDR1: hit_o = gc | own7 | hi10;
      ST_ADDR2: hit_o = !ua_pend_i && (byte_i == own_addr_i[7:0]);
      ST_DATA:  hit_o = 1'b1;
      default:  hit_o = 1'b0;
    endcase
  end

  assign hi10_o = (st_i == ST_ADDR1) && hi10;
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2c_gc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  input  logic              buf_rd_i,
  input  logic              irq_clr_i,
  input  logic              ua_clr_i,
  input  logic              ov_clr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              bf_o,
  output logic              irq_o,
  output logic              ua_o,
  output logic              ov_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  st_q, nxt_q, nxt_st;
  logic [CNT_W-1:0] cnt_q;
  logic oe_q, active, shift_en, byte_done, ack_end;
  logic hit, hi10, bf_busy, accept;
  logic [BYTE_W-1:0] cur_byte;

  i2c_gc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign active    = (st_q != ST_IDLE) && !start_det && !stop_det;
  assign shift_en  = active && scl_rise && (cnt_q < ACK_WAIT);
  assign byte_done = shift_en && (cnt_q == LAST_BIT);
  assign ack_end   = active && scl_fall && (cnt_q == ACK_BIT);

  i2c_gc_shifter #(.W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .shift_i(shift_en), .bit_i(sda_s), .next_byte_o(cur_byte)
  );

  i2c_gc_addr_match u_match (
    .st_i(st_q), .byte_i(cur_byte), .own_addr_i, .gc_en_i, .ten_bit_i,
    .ua_pend_i(ua_o), .hit_o(hit), .hi10_o(hi10)
  );

  // a read in the completing cycle frees the buffer
  assign bf_busy = bf_o && !buf_rd_i;
  assign accept  = hit && !bf_busy;
  assign nxt_st  = hi10 ? ST_ADDR2 : ST_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      nxt_q <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_ADDR1;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (shift_en) begin
        cnt_q <= cnt_q + 1'b1;
        if (byte_done) begin
          if (accept) nxt_q <= nxt_st;
          else        st_q  <= ST_IDLE;
        end
      end else if (scl_fall && cnt_q == ACK_WAIT) begin
        oe_q  <= 1'b1;
        cnt_q <= ACK_BIT;
      end else if (ack_end) begin
        oe_q  <= 1'b0;
        cnt_q <= '0;
        st_q  <= nxt_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      bf_o      <= 1'b0;
      irq_o     <= 1'b0;
      ua_o      <= 1'b0;
      ov_o      <= 1'b0;
    end else begin
      if (byte_done && accept) rx_data_o <= cur_byte;

      if (byte_done && accept) bf_o <= 1'b1;
      else if (buf_rd_i)       bf_o <= 1'b0;

      if (ack_end)        irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;

      if (byte_done && accept && hi10) ua_o <= 1'b1;
      else if (ua_clr_i)               ua_o <= 1'b0;

      if (byte_done && hit && bf_busy) ov_o <= 1'b1;
      else if (ov_clr_i)               ov_o <= 1'b0;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_gc_slave_chk.sv
module i2c_gc_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       irq_o,
  input logic       ua_o,
  input logic       ov_o,
  input logic       bf_o,
  input logic [7:0] rx_data_o,
  input logic       scl_fall,
  input logic       stop_det
);
  // R1: a Stop always leaves SDA released
  p_stop_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R4: the ACK begins only right after a synchronized SCL fall
  p_ack_after_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R6: the interrupt rises together with the end of the ACK
  p_irq_at_ack_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(sda_oe_o));

  // R7: an update request always comes with a buffered 10-bit prefix
  p_ua_prefix_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ua_o) |-> (rx_data_o[7:3] == 5'b11110) && bf_o);

  // R11: an overflow never overwrites the buffer
  p_ov_keeps_buf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ov_o) |-> $stable(rx_data_o));
endmodule

bind i2c_gc_slave i2c_gc_slave_chk u_chk (
  .clk_i, .rst_ni, .sda_oe_o, .irq_o, .ua_o, .ov_o, .bf_o, .rx_data_o,
  .scl_fall(scl_fall), .stop_det(stop_det)
);

// File: tb/test_i2c_gc_slave.sv
module test_i2c_gc_slave;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe_o;
  logic [9:0] own_addr_i = 10'h2A5;
  logic ten_bit_i = 1'b0, gc_en_i = 1'b0;
  logic buf_rd_i = 1'b0, irq_clr_i = 1'b0, ua_clr_i = 1'b0, ov_clr_i = 1'b0;
  logic [7:0] rx_data_o;
  logic bf_o, irq_o, ua_o, ov_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;
  assign sda_line = sda_m & ~sda_oe_o;

  i2c_gc_slave i_i2c_gc_slave (
    .clk_i, .rst_ni, .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o,
    .own_addr_i, .ten_bit_i, .gc_en_i, .buf_rd_i, .irq_clr_i, .ua_clr_i,
    .ov_clr_i, .rx_data_o, .bf_o, .irq_o, .ua_o, .ov_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b, input int rd_at, output logic line);
    scl_m = 1'b0;
    wait_n(3);
    sda_m = b;
    wait_n(3);
    scl_m = 1'b1;
    line = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk_i);
      buf_rd_i = (k == rd_at);
      if (k == 3) line = sda_line;
    end
    buf_rd_i = 1'b0;
  endtask

  // rd_at: negedge index after the eighth rise at which buf_rd_i pulses (0 = none)
  task automatic send_byte(input logic [7:0] b, input int rd_at, output logic ack);
    logic line;
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == 0) ? rd_at : 0, line);
    send_bit(1'b1, 0, line);
    ack = ~line;
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_m = 1'b1;
    wait_n(6);
    sda_m = 1'b0;
    wait_n(6);
  endtask

  task automatic do_stop();
    scl_m = 1'b0;
    wait_n(3);
    sda_m = 1'b0;
    wait_n(3);
    scl_m = 1'b1;
    wait_n(6);
    sda_m = 1'b1;
    wait_n(6);
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    buf_rd_i = 1'b1; irq_clr_i = 1'b1; ua_clr_i = 1'b1; ov_clr_i = 1'b1;
    @(negedge clk_i);
    buf_rd_i = 1'b0; irq_clr_i = 1'b0; ua_clr_i = 1'b0; ov_clr_i = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk_i); buf_rd_i = 1'b1;
    @(negedge clk_i); buf_rd_i = 1'b0;
  endtask

  task automatic pulse_ua_clr();
    @(negedge clk_i); ua_clr_i = 1'b1;
    @(negedge clk_i); ua_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack, exp_ack;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    // reset state
    check("R5 reset bf", bf_o, 0);
    check("R6 reset irq", irq_o, 0);
    check("R7 reset ua", ua_o, 0);
    check("R11 reset ov", ov_o, 0);
    check("R4 reset oe", sda_oe_o, 0);
    check("R5 reset rx", rx_data_o, 0);

    // R2/R3 exhaustive first-byte sweep, 7-bit mode
    for (int g = 0; g < 2; g++) begin
      gc_en_i = g[0];
      for (int b = 0; b < 256; b++) begin
        do_start();
        send_byte(8'(b), 0, ack);
        do_stop();
        exp_ack = (g == 1 && b == 0) || (b[7:1] == own_addr_i[6:0] && b[0] == 1'b0);
        check(b == 0 ? "R3 gc ack" : "R2 addr ack", ack, exp_ack);
        check("R5 bf after byte", bf_o, exp_ack);
        check("R6 irq after ack", irq_o, exp_ack);
        if (exp_ack) check("R5 rx holds address", rx_data_o, 8'(b));
        check("R11 no overflow", ov_o, 0);
        clear_all();
      end
    end

    // R1: bus activity with no Start is ignored
    gc_en_i = 1'b1;
    send_byte(8'h00, 0, ack);
    check("R1 no ack outside frame", ack, 0);
    check("R1 bf untouched", bf_o, 0);
    do_stop();
    check("R1 irq untouched", irq_o, 0);

    // R10: data after own address; R4: idle after refusal
    do_start();
    send_byte({own_addr_i[6:0], 1'b0}, 0, ack);
    pulse_rd();
    for (int d = 0; d < 4; d++) begin
      send_byte(8'(8'h31 * d + 8'h5), 0, ack);
      check("R10 data ack", ack, 1);
      check("R10 data buffered", rx_data_o, 8'(8'h31 * d + 8'h5));
      pulse_rd();
    end
    do_stop();
    clear_all();
    do_start();
    send_byte(8'h7E, 0, ack);
    check("R4 nack mismatch", ack, 0);
    send_byte(8'h00, 0, ack);
    check("R4 idle after refusal", ack, 0);
    do_stop();
    check("R4 bf stays clear", bf_o, 0);
    clear_all();

    // 10-bit mode
    ten_bit_i = 1'b1;
    do_start();
    send_byte(8'hF4, 0, ack);
    check("R7 first half ack", ack, 1);
    check("R7 ua set", ua_o, 1);
    check("R7 rx prefix", rx_data_o, 8'hF4);
    pulse_rd(); pulse_ua_clr();
    send_byte(8'hA5, 0, ack);
    check("R8 second half ack", ack, 1);
    check("R8 rx low addr", rx_data_o, 8'hA5);
    check("R8 ua stays clear", ua_o, 0);
    pulse_rd();
    send_byte(8'h77, 0, ack);
    check("R10 10-bit data ack", ack, 1);
    check("R10 10-bit data rx", rx_data_o, 8'h77);
    do_stop();
    clear_all();

    do_start();
    send_byte(8'hF4, 0, ack);
    pulse_rd();
    send_byte(8'hA5, 0, ack);
    check("R8 nack while ua pending", ack, 0);
    do_stop();
    check("R8 ua still set", ua_o, 1);
    clear_all();

    do_start();
    send_byte(8'hF4, 0, ack);
    pulse_rd(); pulse_ua_clr();
    send_byte(8'hA4, 0, ack);
    check("R8 nack wrong low addr", ack, 0);
    do_stop();
    clear_all();

    do_start();
    send_byte(8'hF6, 0, ack);
    check("R7 nack wrong upper bits", ack, 0);
    do_stop();
    do_start();
    send_byte(8'hF5, 0, ack);
    check("R7 nack read bit", ack, 0);
    do_stop();
    check("R7 no ua on refusal", ua_o, 0);
    clear_all();

    do_start();
    send_byte(8'h00, 0, ack);
    check("R9 gc ack in 10-bit", ack, 1);
    check("R9 ua not set", ua_o, 0);
    check("R5 gc visible in rx", rx_data_o, 8'h00);
    pulse_rd();
    send_byte(8'h33, 0, ack);
    check("R9 next byte is data", ack, 1);
    check("R9 data rx", rx_data_o, 8'h33);
    do_stop();
    clear_all();

    gc_en_i = 1'b0;
    do_start();
    send_byte(8'h00, 0, ack);
    check("R3 gc disabled 10-bit", ack, 0);
    do_stop();
    clear_all();
    gc_en_i = 1'b1;
    ten_bit_i = 1'b0;

    // R11/R12: read vs completion in the same cycle
    do_start();
    send_byte(8'h00, 0, ack);
    send_byte(8'h5A, 2, ack);
    check("R12 coincident read ack", ack, 1);
    check("R12 coincident rx", rx_data_o, 8'h5A);
    check("R12 no overflow", ov_o, 0);
    send_byte(8'h3C, 3, ack);
    check("R11 late read nack", ack, 0);
    check("R11 overflow set", ov_o, 1);
    check("R11 rx unchanged", rx_data_o, 8'h5A);
    check("R11 late read cleared bf", bf_o, 0);
    send_byte(8'h44, 0, ack);
    check("R11 idle after overflow", ack, 0);
    do_stop();
    clear_all();
    check("R11 ov cleared", ov_o, 0);

    do_start();
    send_byte(8'h00, 0, ack);
    send_byte(8'h11, 1, ack);
    check("R12 early read ack", ack, 1);
    check("R12 early rx", rx_data_o, 8'h11);
    do_stop();
    check("R12 early no overflow", ov_o, 0);
    clear_all();

    do_start();
    send_byte(8'h00, 0, ack);
    send_byte(8'h22, 0, ack);
    check("R11 unread nack", ack, 0);
    check("R11 unread ov", ov_o, 1);
    check("R11 unread rx kept", rx_data_o, 8'h00);
    check("R11 bf kept", bf_o, 1);
    do_stop();
    check("R6 irq from first byte", irq_o, 1);
    @(negedge clk_i); irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
    check("R6 irq cleared", irq_o, 0);
    clear_all();

    finish_run();
  end
endmodule